// File: doc/BRIEF.md
# Transfer Command FIFO Controller

This block is the data path of a memory-card host. Software launches a card command with one 32-bit command write that carries a 4-bit command number, a 10-bit byte length and a buffer select bit. The direction (toward the card or from it) is sampled from a separate control input at the same moment. The data bytes pass through a 512-byte FIFO. Software reaches the FIFO through a 32-bit programmed-I/O window. The card side is a plain byte stream with a valid/ready handshake.

The engine counts the bytes that cross the card side and stops the stream when the commanded length is reached. It keeps five sticky flags, which software clears by writing ones: command done, underrun, mismatch, send error and receive error. A read of the window while the FIFO is empty raises underrun. Mismatch is raised in three cases: when the card finishes with a byte count that differs from the commanded length, when a window write finds no room, and when a command is rejected. A command is rejected if its length is zero, if its length exceeds the FIFO depth, or if it selects the small buffer, which is not built here.

Top module: `xfer_cmd_fifo_ctrl`

## Requirements
- R1: The command word holds the command number in bits 31..28, the large-buffer select in bit 26 and the byte length in bits 25..16. When `cmd_valid` is high with a valid command, `busy` is 1 after the next clock edge, `cmd_id` shows the number and `dir_to_card` is captured (1 = toward the card, 0 = from the card).
- R2: In the toward-card direction, a window write puts four bytes into the FIFO. Bits 31..24 go first, then 23..16, 15..8 and 7..0. Bytes leave on `card_tx_data` in that order, one per cycle in which both `card_tx_valid` and `card_tx_ready` are high.
- R3: In the from-card direction, each byte accepted on the card side (`card_rx_valid` and `card_rx_ready` both high) is queued. A window read returns the oldest byte in bits 31..24 and the next bytes below it. When fewer than four bytes are held, the missing low bytes read as zero.
- R4: Once the commanded length has crossed the card side, `card_tx_valid` and `card_rx_ready` stay low even if data or room remains.
- R5: A `card_done` pulse while busy clears `busy` and sets flag bit 0 (done). It sets flag bit 2 (mismatch) only if the byte count differs from the commanded length.
- R6: A window read while `fifo_empty` is 1 returns zero and sets flag bit 1 (underrun).
- R7: A window write when fewer than four bytes are free is dropped and sets flag bit 2 (mismatch).
- R8: A command with length 0, a length above the FIFO depth, or bit 26 clear is rejected. `busy` stays 0, and flag bits 0 and 2 are set one cycle later.
- R9: A `card_err` pulse while busy sets flag bit 3 (send error) in the toward-card direction and flag bit 4 (receive error) in the from-card direction.
- R10: A new command empties the FIFO and restarts the byte count, including a command issued while busy. Flags keep their value until a 1 is written to the matching bit of `flag_clr`. A flag set event wins over a clear in the same cycle.
- R11: `fifo_empty` is 1 exactly when the FIFO holds no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command number, buffer select, length |
| dir_to_card | input | 1 | Direction, sampled with the command |
| pio_wr_valid | input | 1 | Window write strobe |
| pio_wr_data | input | 32 | Window write data, first byte in MSBs |
| pio_rd_req | input | 1 | Window read strobe (pops up to four bytes) |
| pio_rd_data | output | 32 | Window read data, valid while strobe is high |
| card_tx_valid | output | 1 | Byte toward card available |
| card_tx_data | output | 8 | Byte toward card |
| card_tx_ready | input | 1 | Card takes the byte |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Block accepts the byte |
| card_done | input | 1 | Card reports command complete |
| card_err | input | 1 | Card reports a failed transfer |
| flag_clr | input | 5 | Write-one-to-clear for the flags |
| flags | output | 5 | Sticky flags: done, underrun, mismatch, send error, receive error |
| busy | output | 1 | Command in progress |
| cmd_id | output | 4 | Number of the last accepted command |
| fifo_empty | output | 1 | FIFO holds no byte |

## Verification
The toward-card path is run with two distinct words whose bytes are compared one by one. This shows whether the byte order is correct, rather than merely whether data arrives. A length shorter than the data written separates "stream stopped at the count" from "stream stopped on empty". A length longer than the data supplied separates a matched finish from a mismatched one. The from-card path uses six bytes, so one read returns a full word and one returns a half word; this exposes both the packing order and the zero fill. The remaining cases each set a single flag in isolation so that its cause can be told apart: a fill to the full depth plus one word, a read of an empty window, reject lengths at zero and past the depth, and card errors in each direction.

// File: rtl/xcf_pkg.sv
package xcf_pkg;
   localparam int WORD_W  = 32;
   localparam int LEN_W   = 10;
   localparam int NUM_W   = 4;
   localparam int LEN_LSB = 16;
   localparam int BIG_BIT = 26;
   localparam int NUM_LSB = 28;

   localparam int NFLAG     = 5;
   localparam int FLG_DONE  = 0;
   localparam int FLG_UNDER = 1;
   localparam int FLG_MISM  = 2;
   localparam int FLG_SERR  = 3;
   localparam int FLG_RERR  = 4;

   typedef struct packed {
      logic [NUM_W-1:0] num;
      logic             big;
      logic [LEN_W-1:0] len;
   } cmd_t;
endpackage

// File: rtl/xcf_cmd_decode.sv
module xcf_cmd_decode
   import xcf_pkg::*;
#(
   parameter int DEPTH = 512
) (
   input  logic [WORD_W-1:0] word,
   output cmd_t              cmd,
   output logic              ok
);
   logic unused_bits;
   assign unused_bits = ^{word[27], word[15:0]};

   assign cmd.num = word[NUM_LSB +: NUM_W];
   assign cmd.big = word[BIG_BIT];
   assign cmd.len = word[LEN_LSB +: LEN_W];

   // R8: only nonzero lengths that fit the large buffer are runnable
   assign ok = cmd.big && (cmd.len != '0) && (32'(cmd.len) <= 32'(DEPTH));
endmodule

// File: rtl/xcf_byte_fifo.sv
module xcf_byte_fifo #(
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          word_push,
   input  logic [31:0]   word_in,
   input  logic          word_pop,
   output logic [31:0]   word_out,
   input  logic          byte_push,
   input  logic [7:0]    byte_in,
   input  logic          byte_pop,
   output logic [7:0]    byte_out,
   output logic          empty,
   output logic          full,
   output logic          room4
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] level, push_n, pop_n;
   logic          wpush_ok, bpush_ok, bpop_ok;

   assign empty = (level == '0);
   assign full  = (level == CW'(DEPTH));
   assign room4 = (level <= CW'(DEPTH - 4));

   assign wpush_ok = word_push && room4;
   assign bpush_ok = byte_push && !word_push && !full;
   assign bpop_ok  = byte_pop && !word_pop && !empty;

   always_comb begin
      push_n = '0;
      if (wpush_ok)      push_n = CW'(4);
      else if (bpush_ok) push_n = CW'(1);
      pop_n = '0;
      if (word_pop)      pop_n = (level >= CW'(4)) ? CW'(4) : level;
      else if (bpop_ok)  pop_n = CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         wr_ptr <= wr_ptr + push_n[AW-1:0];
         rd_ptr <= rd_ptr + pop_n[AW-1:0];
         level  <= level + push_n - pop_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!clr) begin
         if (wpush_ok) begin
            for (int k = 0; k < 4; k++)
               mem[wr_ptr + AW'(k)] <= word_in[31 - 8*k -: 8];
         end else if (bpush_ok) begin
            mem[wr_ptr] <= byte_in;
         end
      end
   end

   for (genvar k = 0; k < 4; k++) begin : g_lane
      assign word_out[31 - 8*k -: 8] = (level > CW'(k)) ? mem[rd_ptr + AW'(k)] : 8'h00;
   end
   assign byte_out = mem[rd_ptr];

   assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));
   assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);
endmodule

// File: rtl/xcf_sticky_flags.sv
module xcf_sticky_flags #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[i] <= 1'b0;
         else if (set[i]) flag[i] <= 1'b1;
         else if (clr[i]) flag[i] <= 1'b0;
      end
      assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flag[i]);
   end
endmodule

// File: rtl/xfer_cmd_fifo_ctrl.sv
module xfer_cmd_fifo_ctrl
   import xcf_pkg::*;
#(
   parameter int DEPTH = 512
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [31:0] cmd_word,
   input  logic        dir_to_card,
   input  logic        pio_wr_valid,
   input  logic [31:0] pio_wr_data,
   input  logic        pio_rd_req,
   output logic [31:0] pio_rd_data,
   output logic        card_tx_valid,
   output logic [7:0]  card_tx_data,
   input  logic        card_tx_ready,
   input  logic        card_rx_valid,
   input  logic [7:0]  card_rx_data,
   output logic        card_rx_ready,
   input  logic        card_done,
   input  logic        card_err,
   input  logic [4:0]  flag_clr,
   output logic [4:0]  flags,
   output logic        busy,
   output logic [3:0]  cmd_id,
   output logic        fifo_empty
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH >= (1 << LEN_W)) begin : g_bad_depth
      $error("xfer_cmd_fifo_ctrl: DEPTH must be a power of two, at least 4 and below the length range");
   end

   cmd_t             dec;
   logic             dec_ok;
   logic             dir_q;
   logic [LEN_W-1:0] len_q, xfer_cnt;
   logic             cnt_open, finish, hs_tx, hs_rx;
   logic             f_full, f_room4;
   logic [NFLAG-1:0] flag_set;

   xcf_cmd_decode #(.DEPTH(DEPTH)) u_dec (
      .word (cmd_word),
      .cmd  (dec),
      .ok   (dec_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         dir_q    <= 1'b0;
         len_q    <= '0;
         cmd_id   <= '0;
         xfer_cnt <= '0;
      end else if (cmd_valid) begin
         busy     <= dec_ok;
         dir_q    <= dir_to_card;
         len_q    <= dec.len;
         cmd_id   <= dec.num;
         xfer_cnt <= '0;
      end else if (busy) begin
         if (card_done) busy <= 1'b0;
         if (hs_tx || hs_rx) xfer_cnt <= xfer_cnt + 1'b1;
      end
   end

   assign cnt_open = (xfer_cnt < len_q);
   assign finish   = busy && card_done && !cmd_valid;

   assign card_tx_valid = busy && dir_q && !fifo_empty && cnt_open &&
                          !pio_rd_req && !cmd_valid && !card_done;
   assign card_rx_ready = busy && !dir_q && !f_full && cnt_open &&
                          !pio_wr_valid && !cmd_valid && !card_done;
   assign hs_tx = card_tx_valid && card_tx_ready;
   assign hs_rx = card_rx_valid && card_rx_ready;

   xcf_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cmd_valid),
      .word_push (pio_wr_valid && !cmd_valid),
      .word_in   (pio_wr_data),
      .word_pop  (pio_rd_req && !cmd_valid),
      .word_out  (pio_rd_data),
      .byte_push (hs_rx),
      .byte_in   (card_rx_data),
      .byte_pop  (hs_tx),
      .byte_out  (card_tx_data),
      .empty     (fifo_empty),
      .full      (f_full),
      .room4     (f_room4)
   );

   always_comb begin
      flag_set            = '0;
      flag_set[FLG_DONE]  = finish || (cmd_valid && !dec_ok);
      flag_set[FLG_UNDER] = pio_rd_req && fifo_empty;
      flag_set[FLG_MISM]  = (cmd_valid && !dec_ok) ||
                            (finish && (xfer_cnt != len_q)) ||
                            (pio_wr_valid && !cmd_valid && !f_room4);
      flag_set[FLG_SERR]  = busy && card_err && dir_q;
      flag_set[FLG_RERR]  = busy && card_err && !dir_q;
   end

   xcf_sticky_flags #(.N(NFLAG)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flag  (flags)
   );

   assert_count_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (xfer_cnt <= len_q));
   assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (!busy && flags[FLG_DONE]));
   assert_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_rd_req && fifo_empty) |=> flags[FLG_UNDER]);
   assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !dec_ok) |=> (!busy && flags[FLG_DONE] && flags[FLG_MISM]));
   assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && dec_ok) |=> (busy && cmd_id == $past(dec.num)));
endmodule

// File: tb/xfer_cmd_fifo_ctrl_bench.sv
module xfer_cmd_fifo_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_word = '0;
   logic        dir_to_card = 1'b0;
   logic        pio_wr_valid = 1'b0;
   logic [31:0] pio_wr_data = '0;
   logic        pio_rd_req = 1'b0;
   logic [31:0] pio_rd_data;
   logic        card_tx_valid;
   logic [7:0]  card_tx_data;
   logic        card_tx_ready = 1'b0;
   logic        card_rx_valid = 1'b0;
   logic [7:0]  card_rx_data = '0;
   logic        card_rx_ready;
   logic        card_done = 1'b0;
   logic        card_err = 1'b0;
   logic [4:0]  flag_clr = '0;
   logic [4:0]  flags;
   logic        busy;
   logic [3:0]  cmd_id;
   logic        fifo_empty;

   int          n_checks = 0;
   int          n_err = 0;
   bit          run_over = 1'b0;
   logic [7:0]  exp_q[$];
   logic [7:0]  exp_b;
   logic [31:0] rd_w;

   always #5 clk = ~clk;

   xfer_cmd_fifo_ctrl u_xfer_cmd_fifo_ctrl (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic send_cmd(input logic [3:0] num, input logic [9:0] len,
                           input logic big, input logic dir);
      cmd_word    = {num, 1'b0, big, len, 16'h0000};
      dir_to_card = dir;
      cmd_valid   = 1'b1;
      tick();
      cmd_valid   = 1'b0;
   endtask

   // driver: queues the bytes the card should see from this word
   task automatic pio_write(input logic [31:0] w, input int expect_n);
      for (int k = 0; k < expect_n; k++) exp_q.push_back(w[31 - 8*k -: 8]);
      pio_wr_data  = w;
      pio_wr_valid = 1'b1;
      tick();
      pio_wr_valid = 1'b0;
   endtask

   task automatic pio_read(output logic [31:0] w);
      pio_rd_req = 1'b1;
      @(negedge clk);
      w = pio_rd_data;
      tick();
      pio_rd_req = 1'b0;
   endtask

   task automatic pulse_done();
      card_done = 1'b1;
      tick();
      card_done = 1'b0;
   endtask

   task automatic clear_flags();
      flag_clr = 5'h1f;
      tick();
      flag_clr = 5'h00;
   endtask

   // monitor: compares every byte the card takes against the queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && card_tx_valid && card_tx_ready) begin
            if (exp_q.size() == 0) begin
               chk("R4 unexpected card byte", {24'h0, card_tx_data}, 32'hxxxx_xxxx);
            end else begin
               exp_b = exp_q.pop_front();
               chk("R2 card byte order", {24'h0, card_tx_data}, {24'h0, exp_b});
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!run_over) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 reset busy", {31'h0, busy}, 32'h0);
      chk("R11 reset empty", {31'h0, fifo_empty}, 32'h1);
      chk("R10 reset flags", {27'h0, flags}, 32'h0);

      // R1, R2: full-length write toward the card
      send_cmd(4'hA, 10'd8, 1'b1, 1'b1);
      chk("R1 busy after command", {31'h0, busy}, 32'h1);
      chk("R1 command id", {28'h0, cmd_id}, 32'hA);
      pio_write(32'h11223344, 4);
      pio_write(32'h55667788, 4);
      chk("R11 empty after writes", {31'h0, fifo_empty}, 32'h0);
      card_tx_ready = 1'b1;
      repeat (12) tick();
      chk("R2 all bytes sent", exp_q.size(), 32'd0);
      chk("R11 empty after drain", {31'h0, fifo_empty}, 32'h1);
      pulse_done();
      chk("R5 busy cleared", {31'h0, busy}, 32'h0);
      chk("R5 done flag", {31'h0, flags[0]}, 32'h1);
      chk("R5 no mismatch on match", {31'h0, flags[2]}, 32'h0);
      clear_flags();
      chk("R10 flags cleared", {27'h0, flags}, 32'h0);

      // R4: length shorter than data supplied
      card_tx_ready = 1'b0;
      send_cmd(4'h3, 10'd5, 1'b1, 1'b1);
      pio_write(32'hA0A1A2A3, 4);
      pio_write(32'hA4A5A6A7, 1);
      card_tx_ready = 1'b1;
      repeat (10) tick();
      chk("R4 stream stopped at length", {31'h0, card_tx_valid}, 32'h0);
      chk("R4 leftover data kept", {31'h0, fifo_empty}, 32'h0);
      pulse_done();
      chk("R5 count equals length", {29'h0, flags[2:0]}, 32'h1);
      clear_flags();

      // R5: card finishes short
      send_cmd(4'h4, 10'd6, 1'b1, 1'b1);
      pio_write(32'hDEADBEEF, 4);
      repeat (8) tick();
      pulse_done();
      chk("R5 short count mismatch", {31'h0, flags[2]}, 32'h1);
      chk("R5 done on short", {31'h0, flags[0]}, 32'h1);
      clear_flags();
      card_tx_ready = 1'b0;

      // R3: six bytes from the card
      send_cmd(4'h5, 10'd6, 1'b1, 1'b0);
      for (int b = 0; b < 6; b++) begin
         card_rx_data  = 8'hC1 + 8'(b);
         card_rx_valid = 1'b1;
         @(negedge clk);
         chk("R3 rx ready during transfer", {31'h0, card_rx_ready}, 32'h1);
         tick();
      end
      card_rx_data = 8'hEE;
      @(negedge clk);
      chk("R4 rx ready low at length", {31'h0, card_rx_ready}, 32'h0);
      tick();
      card_rx_valid = 1'b0;
      pio_read(rd_w);
      chk("R3 full word packing", rd_w, 32'hC1C2C3C4);
      pio_read(rd_w);
      chk("R3 partial word zero fill", rd_w, 32'hC5C60000);
      chk("R11 empty after reads", {31'h0, fifo_empty}, 32'h1);
      chk("R6 no underrun yet", {31'h0, flags[1]}, 32'h0);
      pulse_done();
      chk("R5 read count matched", {29'h0, flags[2:0]}, 32'h1);
      clear_flags();

      // R6: read of empty window
      pio_read(rd_w);
      chk("R6 empty read data", rd_w, 32'h0);
      chk("R6 underrun flag", {31'h0, flags[1]}, 32'h1);
      clear_flags();

      // R7: overfill, then R10: restart keeps flags
      send_cmd(4'h6, 10'd512, 1'b1, 1'b1);
      for (int w = 0; w < 128; w++) pio_write(32'(w), 0);
      chk("R7 no mismatch at depth", {31'h0, flags[2]}, 32'h0);
      pio_write(32'hFFFFFFFF, 0);
      chk("R7 overflow mismatch", {31'h0, flags[2]}, 32'h1);
      send_cmd(4'h7, 10'd4, 1'b1, 1'b1);
      chk("R10 restart empties fifo", {31'h0, fifo_empty}, 32'h1);
      chk("R10 restart keeps flag", {31'h0, flags[2]}, 32'h1);
      chk("R10 restart busy", {31'h0, busy}, 32'h1);
      pulse_done();
      clear_flags();

      // R8: rejected commands
      send_cmd(4'h8, 10'd0, 1'b1, 1'b1);
      chk("R8 zero length busy", {31'h0, busy}, 32'h0);
      chk("R8 zero length flags", {27'h0, flags}, 32'h5);
      clear_flags();
      send_cmd(4'h9, 10'd600, 1'b1, 1'b1);
      chk("R8 oversize flags", {27'h0, flags}, 32'h5);
      clear_flags();
      send_cmd(4'h9, 10'd8, 1'b0, 1'b1);
      chk("R8 small buffer busy", {31'h0, busy}, 32'h0);
      chk("R8 small buffer flags", {27'h0, flags}, 32'h5);
      clear_flags();

      // R9: card errors in each direction
      send_cmd(4'h2, 10'd4, 1'b1, 1'b1);
      card_err = 1'b1; tick(); card_err = 1'b0;
      chk("R9 send error", {30'h0, flags[4:3]}, 32'h1);
      pulse_done();
      clear_flags();
      send_cmd(4'h2, 10'd4, 1'b1, 1'b0);
      card_err = 1'b1; tick(); card_err = 1'b0;
      chk("R9 receive error", {30'h0, flags[4:3]}, 32'h2);
      pulse_done();
      clear_flags();

      run_over = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule